// File: doc/BRIEF.md
# Timer Capture/Compare Channel Array

The block holds a free-running counter and a set of channels attached to it. Each channel owns one value register. A direction bit decides what that register does. In capture mode the register takes a snapshot of the counter when the chosen transition shows up on the channel pin. In compare mode the register holds a target value. The channel then signals a match when the running counter reaches that target.

Software reaches the block over a small word-wide register bus: address, write strobe, write data and combinational read data. Every register is read and written as a whole 16-bit word, so a read of a counter snapshot is always coherent. Each channel has a sticky event flag that is cleared by writing 1 to it. The counter has an overflow flag that behaves the same way. The counter advances only while the global enable is high. Capture still works while the counter is stopped, and the frozen value is latched.

Register map (word addresses): 0 to 3 are the channel value registers. 4 is control. 5 is flags. 6 is the counter, which is read-only. Address 7 reads zero.

Top module: `cc_timer_top`

## Requirements
- R1: After reset, all channel registers, the control register, the flags and the counter read 0, and flag_o, ovf_o and match_o are low.
- R2: The counter (address 6) increments by one on each clock edge at which en_i is high and holds while en_i is low. Bus writes to address 6 have no effect.
- R3: When the counter steps from 0xFFFF to 0, the overflow flag (flag register bit 4, and ovf_o) is set. It stays set until 1 is written to bit 4 of address 5.
- R4: The control register (address 4) holds the direction bits in bits 3:0, with bit n for channel n: 0 selects capture and 1 selects compare. It holds the 2-bit edge select of channel n in bits 5+2n:4+2n. It reads back what was written, and bits 15:12 read 0.
- R5: In capture mode, an edge on pin_i[n] that matches the edge select (01 rising, 10 falling, 11 either) latches the current counter value into channel n and sets flag n. The edge is seen after a two-flop synchronizer.
- R6: Edge select 00 disables capture. A transition that the edge select does not name leaves both the register and the flag unchanged.
- R7: A bus write to a channel in capture mode is ignored. A bus write in compare mode updates the register. Changing the mode keeps the register value.
- R8: In compare mode, match_o[n] is high while en_i is high and the counter equals the channel register. flag n is set at that clock edge. No match occurs while en_i is low.
- R9: The channel flags (address 5, bits 3:0, mirrored on flag_o) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global counter enable |
| addr_i | input | 3 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| pin_i | input | 4 | Channel input pins, asynchronous |
| flag_o | output | 4 | Sticky per-channel event flags |
| ovf_o | output | 1 | Sticky counter overflow flag |
| match_o | output | 4 | Per-channel compare match, high while matching |

## Verification
The bench freezes the counter to learn its value, then toggles pins under each edge select. This exposes a design that captures on the wrong polarity, or one that still captures with the select at 00. It writes to a channel in capture mode and then reads it back. A design that does not gate writes by direction returns the written data instead of the old value. It stops the counter exactly on a compare value and then restarts it. This shows whether match depends on the enable and whether the flag lands on the correct edge. It also runs the counter through the full 0xFFFF to 0 wrap, to catch an overflow flag that is missing or fires early. Writes of 0 and of partial masks to the flag register separate true write-1-to-clear from a plain overwrite.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/cc_counter.sv
module cc_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i && (cnt_q == {CW{1'b1}});

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cc_edge_det.sv
module cc_edge_det
  import cc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] esel_i,
  output logic       evt_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    unique case (edge_sel_e'(esel_i))
      EDGE_RISE: evt_o = s2_q & ~s3_q;
      EDGE_FALL: evt_o = ~s2_q & s3_q;
      EDGE_BOTH: evt_o = s2_q ^ s3_q;
      default:   evt_o = 1'b0;
    endcase
  end

  // R6
  edge_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esel_i == 2'b00) |-> !evt_o);
endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dir_i,
  input  logic          evt_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          clr_i,
  output logic [CW-1:0] val_o,
  output logic          flag_o,
  output logic          match_o
);
  logic [CW-1:0] val_q;
  logic          flag_q;
  logic          cap;

  assign cap     = !dir_i && evt_i;
  assign match_o = dir_i && en_i && (cnt_i == val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             val_q <= '0;
    else if (cap)            val_q <= cnt_i;
    else if (dir_i && we_i)  val_q <= wdata_i;
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (cap || match_o)     flag_q <= 1'b1;
    else if (clr_i)              flag_q <= 1'b0;
  end

  assign val_o  = val_q;
  assign flag_o = flag_q;

  // R5
  capture_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> (val_q == $past(cnt_i)) && flag_q);
  // R7
  cap_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_i && !evt_i) |=> $stable(val_q));
  // R8
  match_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> flag_q);
  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/cc_timer_top.sv
module cc_timer_top #(
  parameter int NUM_CH = 4,
  parameter int CW     = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     rdata_o,
  input  logic [NUM_CH-1:0] pin_i,
  output logic [NUM_CH-1:0] flag_o,
  output logic              ovf_o,
  output logic [NUM_CH-1:0] match_o
);
  localparam int CTRL_W = 3 * NUM_CH;
  localparam int CTRL_A = NUM_CH;
  localparam int FLAG_A = NUM_CH + 1;
  localparam int CNT_A  = NUM_CH + 2;

  logic [CW-1:0]     cnt;
  logic              wrap;
  logic [CTRL_W-1:0] ctrl_q;
  logic              ovf_q;
  logic [CW-1:0]     ch_val [NUM_CH];
  logic [NUM_CH-1:0] ch_flag;
  logic              ctrl_we, flag_we;

  assign ctrl_we = we_i && (addr_i == ADDR_W'(CTRL_A));
  assign flag_we = we_i && (addr_i == ADDR_W'(FLAG_A));

  cc_counter #(.CW(CW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cnt_o(cnt), .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ovf_q <= 1'b0;
    else if (wrap)                     ovf_q <= 1'b1;
    else if (flag_we && wdata_i[NUM_CH]) ovf_q <= 1'b0;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic evt;

    cc_edge_det u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_i[n]),
      .esel_i(ctrl_q[NUM_CH+2*n +: 2]),
      .evt_o (evt)
    );

    cc_channel #(.CW(CW)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .dir_i  (ctrl_q[n]),
      .evt_i  (evt),
      .cnt_i  (cnt),
      .we_i   (we_i && (addr_i == ADDR_W'(n))),
      .wdata_i(wdata_i),
      .clr_i  (flag_we && wdata_i[n]),
      .val_o  (ch_val[n]),
      .flag_o (ch_flag[n]),
      .match_o(match_o[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = ch_val[i];
    if (addr_i == ADDR_W'(CTRL_A)) rdata_o = CW'(ctrl_q);
    if (addr_i == ADDR_W'(FLAG_A)) rdata_o = CW'({ovf_q, ch_flag});
    if (addr_i == ADDR_W'(CNT_A))  rdata_o = cnt;
  end

  assign flag_o = ch_flag;
  assign ovf_o  = ovf_q;

  // R3
  wrap_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_q);
  // R3
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(flag_we && wdata_i[NUM_CH])) |=> ovf_q);
  // R4
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(ctrl_q));
endmodule

// File: tb/cc_timer_top_test.sv
module cc_timer_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  pin = '0;
  logic [3:0]  flag;
  logic        ovf;
  logic [3:0]  match;

  int checks = 0;
  int fails = 0;
  int cnt_model = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_timer_top uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .flag_o(flag),
    .ovf_o(ovf), .match_o(match)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic run(int n);
    @(negedge clk);
    en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    en = 1'b0;
    cnt_model = (cnt_model + n) % 65536;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int i = 0; i < 7; i++) begin
      rd(3'(i), d);
      chk("R1 reg", d, 16'h0);
    end
    chk("R1 outs", {7'd0, ovf, flag, match}, 16'h0);
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    wr(3'd4, 16'h0FF5);
    rd(3'd4, d); chk("R4 ctrl readback", d, 16'h0FF5);
    wr(3'd4, 16'hFFFF);
    rd(3'd4, d); chk("R4 upper bits zero", d, 16'h0FFF);
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_write_mode();
    logic [15:0] d;
    wr(3'd1, 16'h1234);
    rd(3'd1, d); chk("R7 capture write ignored", d, 16'h0000);
    wr(3'd4, 16'h0002);
    wr(3'd1, 16'h1234);
    rd(3'd1, d); chk("R7 compare write", d, 16'h1234);
    wr(3'd4, 16'h0000);
    rd(3'd1, d); chk("R7 mode switch keeps value", d, 16'h1234);
  endtask

  task automatic t_counter();
    logic [15:0] d;
    run(100);
    rd(3'd6, d); chk("R2 count", d, 16'(cnt_model));
    repeat (10) @(negedge clk);
    wr(3'd6, 16'h5555);
    rd(3'd6, d); chk("R2 hold and no write", d, 16'(cnt_model));
  endtask

  task automatic t_capture();
    logic [15:0] d;
    logic [15:0] c1;
    c1 = 16'(cnt_model);
    // ch0 rise, ch1 off, ch2 fall, ch3 both, all capture mode
    wr(3'd4, 16'h0E10);
    @(negedge clk); pin = 4'hF;
    repeat (5) @(negedge clk);
    rd(3'd0, d); chk("R5 rise capture", d, c1);
    rd(3'd1, d); chk("R6 off no capture", d, 16'h1234);
    rd(3'd2, d); chk("R6 fall ignores rise", d, 16'h0000);
    rd(3'd3, d); chk("R5 both on rise", d, c1);
    chk("R5 flags after rise", {12'd0, flag}, 16'h0009);
    run(50);
    @(negedge clk); pin = 4'h0;
    repeat (5) @(negedge clk);
    rd(3'd0, d); chk("R6 rise ignores fall", d, c1);
    rd(3'd2, d); chk("R5 fall capture", d, 16'(cnt_model));
    rd(3'd3, d); chk("R5 both on fall", d, 16'(cnt_model));
    rd(3'd5, d); chk("R5 flag reg", d, 16'h000D);
  endtask

  task automatic t_flags();
    logic [15:0] d;
    wr(3'd5, 16'h0000);
    rd(3'd5, d); chk("R9 write zero keeps", d, 16'h000D);
    wr(3'd5, 16'h0001);
    rd(3'd5, d); chk("R9 partial clear", d, 16'h000C);
    wr(3'd5, 16'h000C);
    chk("R9 all clear", {12'd0, flag}, 16'h0000);
  endtask

  task automatic t_compare();
    logic [15:0] d;
    wr(3'd4, 16'h0E11);
    wr(3'd0, 16'd200);
    run(200 - cnt_model - 1);
    chk("R8 no flag before", {12'd0, flag}, 16'h0000);
    run(1);
    #1 chk("R8 no match while stopped", {12'd0, match}, 16'h0000);
    chk("R8 no flag while stopped", {12'd0, flag}, 16'h0000);
    @(negedge clk); en = 1'b1;
    #1 chk("R8 match high", {12'd0, match}, 16'h0001);
    @(negedge clk); en = 1'b0;
    cnt_model = cnt_model + 1;
    #1 chk("R8 match flag", {12'd0, flag}, 16'h0001);
    chk("R8 match drops", {12'd0, match}, 16'h0000);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    run(65535 - cnt_model);
    rd(3'd5, d); chk("R3 no ovf before wrap", d, 16'h0001);
    run(1);
    rd(3'd6, d); chk("R3 wrapped count", d, 16'h0000);
    rd(3'd5, d); chk("R3 ovf set", d, 16'h0011);
    chk("R3 ovf port", {15'd0, ovf}, 16'h0001);
    wr(3'd5, 16'h0010);
    rd(3'd5, d); chk("R3 ovf cleared", d, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_write_mode();
    t_counter();
    t_capture();
    t_flags();
    t_compare();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule